// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block receives asynchronous serial characters on a single input line that is sampled at sixteen times the bit rate. An external pulse, one clock wide, marks each oversample point. The block finds the start bit, recovers 5 to 9 data bits least significant bit first, and can check an optional parity bit. It then checks the stop bit and places the character, with its own framing and parity error flags, into a small receive queue. A sticky overrun flag records a character that arrived while the queue had no room.

The queue output is a valid/ready stream. `rx_valid` is high whenever at least one character is held. A character leaves the queue on a clock edge where `rx_valid` and `rx_ready` are both high. While `rx_ready` is held low, the head character and its flags stay unchanged. The ninth bit and the low byte of a character are taken from the same entry, so they always belong together. A consumer that reads the ninth bit before it accepts the low byte therefore gets a consistent pair. Dropping the receive enable empties the queue at once, and every pending error indication is lost with it.

Top module: `uart_rx_flush`

## Requirements
- R1: After reset, `rx_valid`, `rx_ovr` and `rx_pin_own` are low.
- R2: `rx_pin_own` is high exactly when `rx_en` is high, which marks that the receiver owns the serial pin.
- R3: A character is framed as follows: a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop bit, each lasting 16 ticks. This character appears on `rx_data` with `rx_ferr` and `rx_perr` low.
- R4: `rx_size` selects the number of data bits: 000=5, 001=6, 010=7, 011=8, 111=9, and 100/101/110 are taken as 8. Data bits that are not received read as zero. The ninth bit appears on `rx_bit8`.
- R5: When `rx_par_en` is high, a parity bit follows the data. `rx_par_odd`=0 selects even parity and 1 selects odd parity. On a mismatch, `rx_perr` is set for that character only.
- R6: A stop bit that reads low stores the character with `rx_ferr` set.
- R7: A low pulse on the line is treated as a false start and ignored if the line is high again at the middle of the start bit (tick 8).
- R8: The queue holds 2 characters. `rx_valid` is high while the queue is not empty. While `rx_ready` is low, the head data and flags stay stable.
- R9: A character that completes while the queue is full and not being popped is discarded and sets `rx_ovr`. `rx_ovr` clears on the next pop.
- R10: While `rx_en` is low, the queue is emptied and `rx_ovr` is cleared on the next clock edge. No reception takes place.
- R11: The ninth bit and the low byte of each character come from the same queue entry, and both advance together on a pop.
- R12: Each data bit is decided by a 2-of-3 majority of ticks 7, 8 and 9, so a glitch of one tick does not change the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low flushes the queue |
| rx_tick | input | 1 | Oversample pulse, 16 per bit |
| rx_line | input | 1 | Serial input line, idle high |
| rx_size | input | 3 | Character size code |
| rx_par_en | input | 1 | Parity bit present and checked |
| rx_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_valid | output | 1 | Queue holds a character |
| rx_ready | input | 1 | Consumer accepts the head character |
| rx_data | output | 8 | Low eight data bits of the head character |
| rx_bit8 | output | 1 | Ninth data bit of the head character |
| rx_ferr | output | 1 | Framing error of the head character |
| rx_perr | output | 1 | Parity error of the head character |
| rx_ovr | output | 1 | Sticky overrun flag |
| rx_pin_own | output | 1 | Receiver owns the serial pin |

## Verification
The bench sends three characters without popping. A design that overwrote the queue head, or that held the overrun flag past a pop, would show the wrong first byte or a stale `rx_ovr`. It drops the enable while the queue is full and overflowed. A lazy flush would leave `rx_valid` or `rx_ovr` high. It also sends a short low pulse, a one-tick glitch at mid-bit, bad parity and a low stop bit. A design without start confirmation would produce a spurious character. A design that sampled only once would flip a data bit. Error flags that were not tied to their character would show up on the wrong entry. Paired 9-bit characters catch a ninth bit taken from the wrong entry.

// File: rtl/uart_rx_flush_pkg.sv
package uart_rx_flush_pkg;

  typedef struct packed {
    logic       ferr;
    logic       perr;
    logic [8:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_t;

  // size code to data-bit count; unlisted codes fall back to eight bits
  function automatic logic [3:0] size_to_bits(input logic [2:0] code);
    logic [3:0] n;
    case (code)
      3'b000:  n = 4'd5;
      3'b001:  n = 4'd6;
      3'b010:  n = 4'd7;
      3'b011:  n = 4'd8;
      3'b111:  n = 4'd9;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_flush_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       line_s,
  input  logic [2:0] size_code,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       push,
  output rx_char_t   char_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] V_LO  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] V_MID = CW'(OSR / 2);
  localparam logic [CW-1:0] V_HI  = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);

  rx_state_t   state;
  logic [CW-1:0] cnt;
  logic [3:0]  idx;
  logic [8:0]  shreg;
  logic        pbit;
  logic        vote_a, vote_b;
  logic        maj;
  logic [3:0]  last_idx;
  logic        perr_calc;

  assign last_idx  = size_to_bits(size_code) - 4'd1;
  assign maj       = (vote_a & vote_b) | (vote_a & line_s) | (vote_b & line_s);
  assign perr_calc = par_en & ((^shreg ^ pbit) != par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      pbit   <= 1'b0;
      vote_a <= 1'b1;
      vote_b <= 1'b1;
      push   <= 1'b0;
      char_o <= '0;
    end else if (!en) begin
      state <= S_IDLE;
      cnt   <= '0;
      push  <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        if (state == S_IDLE) begin
          if (!line_s) begin
            state <= S_START;
            cnt   <= CW'(1);
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
          end
        end else begin
          if (cnt == V_LO)  vote_a <= line_s;
          if (cnt == V_MID) vote_b <= line_s;
          if (state == S_START && cnt == V_MID && line_s) state <= S_IDLE;
          if (cnt == V_HI) begin
            case (state)
              S_DATA: shreg[idx] <= maj;
              S_PAR:  pbit <= maj;
              S_STOP: begin
                push   <= 1'b1;
                char_o <= '{ferr: ~maj, perr: perr_calc, data: shreg};
                state  <= S_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt == LAST) begin
            cnt <= '0;
            case (state)
              S_START: begin
                state <= S_DATA;
                idx   <= '0;
              end
              S_DATA: begin
                if (idx == last_idx) state <= par_en ? S_PAR : S_STOP;
                else                 idx   <= idx + 4'd1;
              end
              S_PAR:   state <= S_STOP;
              default: ;
            endcase
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end

  // R10: receiving stops as soon as the enable drops
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == S_IDLE && !push));

  // R3: a completed character is announced for a single cycle
  a_r3_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  // R7: a start bit that is high at mid-bit returns to idle
  a_r7_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && state == S_START && cnt == V_MID && line_s) |=> state == S_IDLE);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             valid,
  input  logic             ready,
  output logic [WIDTH-1:0] dout,
  output logic             ovr
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [AW-1:0]   TOP_PTR  = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CNTW-1:0]  count;
  logic             pop, accept, overflow;

  assign valid    = (count != '0);
  assign pop      = valid & ready;
  assign accept   = push & ((count != FULL_CNT) | pop);
  assign overflow = push & ~accept;
  assign dout     = mem[rptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (accept) wptr <= (wptr == TOP_PTR) ? '0 : wptr + AW'(1);
      if (pop)    rptr <= (rptr == TOP_PTR) ? '0 : rptr + AW'(1);
      count <= count + CNTW'(accept) - CNTW'(pop);
      if (overflow) ovr <= 1'b1;
      else if (pop) ovr <= 1'b0;
    end
  end

  // R8: occupancy never exceeds the queue depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R8: a stalled head stays put
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !flush) |=> (valid && $stable(dout)));

  // R9: a dropped character leaves the queue full and flags the overrun
  a_r9_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> (ovr && count == FULL_CNT));

  // R9: a pop with no new drop clears the overrun flag
  a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !overflow && !flush) |=> !ovr);

  // R10: a flush empties everything on the next edge
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !ovr));
endmodule

// File: rtl/uart_rx_flush.sv
module uart_rx_flush
  import uart_rx_flush_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_tick,
  input  logic       rx_line,
  input  logic [2:0] rx_size,
  input  logic       rx_par_en,
  input  logic       rx_par_odd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_ferr,
  output logic       rx_perr,
  output logic       rx_ovr,
  output logic       rx_pin_own
);
  localparam int ENTRY_W = $bits(rx_char_t);

  logic     line_s;
  logic     push;
  rx_char_t new_char;
  rx_char_t head;

  assign rx_pin_own = rx_en;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  uart_rx_framer #(.OSR(OSR)) i_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .tick     (rx_tick),
    .line_s   (line_s),
    .size_code(rx_size),
    .par_en   (rx_par_en),
    .par_odd  (rx_par_odd),
    .push     (push),
    .char_o   (new_char)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) i_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(~rx_en),
    .push (push),
    .din  (new_char),
    .valid(rx_valid),
    .ready(rx_ready),
    .dout (head),
    .ovr  (rx_ovr)
  );

  assign rx_data = head.data[7:0];
  assign rx_bit8 = head.data[8];
  assign rx_ferr = head.ferr;
  assign rx_perr = head.perr;

  // R10: the port shows an empty, clean queue after the enable drops
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_valid && !rx_ovr));

  // R11: the pair advances together; a stalled head keeps both parts
  a_r11_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && rx_en) |=> ($stable(rx_data) && $stable(rx_bit8)));
endmodule

// File: tb/test_uart_rx_flush.sv
module test_uart_rx_flush;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       rx_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [2:0] rx_size = 3'b011;
  logic       rx_par_en = 1'b0;
  logic       rx_par_odd = 1'b0;
  logic       rx_ready = 1'b0;
  logic       rx_valid, rx_bit8, rx_ferr, rx_perr, rx_ovr, rx_pin_own;
  logic [7:0] rx_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  uart_rx_flush i_uart_rx_flush (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_tick(rx_tick), .rx_line(rx_line),
    .rx_size(rx_size), .rx_par_en(rx_par_en), .rx_par_odd(rx_par_odd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_bit8(rx_bit8),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr), .rx_pin_own(rx_pin_own)
  );

  always #10 clk = ~clk;

  // oversample pulse: one clock in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      rx_tick = 1'b1;
      @(negedge clk);
      rx_tick = 1'b0;
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hold_bits(input int ticks);
    repeat (ticks * 4) @(negedge clk);
  endtask

  // one character on the line, then an idle gap
  task automatic send(input logic [8:0] d, input int nbits, input bit pen,
                      input bit podd, input bit pflip, input bit stopv,
                      input int glitch_bit);
    logic [8:0] dm;
    logic       p;
    dm = d & ((9'h1 << nbits) - 9'h1);
    p  = (^dm) ^ podd ^ pflip;
    rx_line = 1'b0;
    hold_bits(16);
    for (int i = 0; i < nbits; i++) begin
      rx_line = d[i];
      if (i == glitch_bit) begin
        hold_bits(8);
        rx_line = ~d[i];
        hold_bits(1);
        rx_line = d[i];
        hold_bits(7);
      end else begin
        hold_bits(16);
      end
    end
    if (pen) begin
      rx_line = p;
      hold_bits(16);
    end
    rx_line = stopv;
    hold_bits(16);
    rx_line = 1'b1;
    hold_bits(32);
  endtask

  task automatic pop();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "valid", rx_valid, 0);
    chk("R1", "ovr", rx_ovr, 0);
    chk("R1", "pin_own", rx_pin_own, 0);
  endtask

  task automatic t_pin_own();
    @(negedge clk) rx_en = 1'b1;
    #1 chk("R2", "pin_own on", rx_pin_own, 1);
    @(negedge clk);
  endtask

  task automatic t_basic();
    rx_size = 3'b011;
    send(9'h0A5, 8, 0, 0, 0, 1, -1);
    chk("R3", "valid", rx_valid, 1);
    chk("R3", "data", rx_data, 8'hA5);
    chk("R3", "ferr", rx_ferr, 0);
    chk("R3", "perr", rx_perr, 0);
    pop();
    chk("R8", "empty after pop", rx_valid, 0);
  endtask

  task automatic t_sizes();
    rx_size = 3'b000; send(9'h1F5, 5, 0, 0, 0, 1, -1);
    chk("R4", "5-bit data", rx_data, 8'h15); pop();
    rx_size = 3'b001; send(9'h0EA, 6, 0, 0, 0, 1, -1);
    chk("R4", "6-bit data", rx_data, 8'h2A); pop();
    rx_size = 3'b010; send(9'h0D5, 7, 0, 0, 0, 1, -1);
    chk("R4", "7-bit data", rx_data, 8'h55); pop();
    rx_size = 3'b100; send(9'h0C3, 8, 0, 0, 0, 1, -1);
    chk("R4", "code 100 as 8 bits", rx_data, 8'hC3); pop();
    rx_size = 3'b111; send(9'h1A5, 9, 0, 0, 0, 1, -1);
    chk("R4", "9-bit low", rx_data, 8'hA5);
    chk("R4", "9-bit ninth", rx_bit8, 1); pop();
    rx_size = 3'b011;
  endtask

  task automatic t_parity();
    rx_par_en = 1'b1;
    rx_par_odd = 1'b0;
    send(9'h037, 8, 1, 0, 0, 1, -1);
    chk("R5", "even ok data", rx_data, 8'h37);
    chk("R5", "even ok perr", rx_perr, 0); pop();
    rx_par_odd = 1'b1;
    send(9'h037, 8, 1, 1, 1, 1, -1);
    chk("R5", "odd bad perr", rx_perr, 1);
    chk("R5", "odd bad data", rx_data, 8'h37); pop();
    send(9'h080, 8, 1, 1, 0, 1, -1);
    chk("R5", "odd ok perr", rx_perr, 0); pop();
    rx_par_en = 1'b0;
    rx_par_odd = 1'b0;
  endtask

  task automatic t_frame();
    send(9'h05A, 8, 0, 0, 0, 0, -1);
    chk("R6", "ferr", rx_ferr, 1);
    chk("R6", "data kept", rx_data, 8'h5A);
    hold_bits(32);
    chk("R6", "no extra char", rx_valid, 1); pop();
    chk("R6", "queue empty", rx_valid, 0);
  endtask

  task automatic t_false_start();
    rx_line = 1'b0;
    hold_bits(4);
    rx_line = 1'b1;
    hold_bits(16 * 12);
    chk("R7", "no char from short pulse", rx_valid, 0);
    send(9'h03C, 8, 0, 0, 0, 1, -1);
    chk("R7", "recovery data", rx_data, 8'h3C); pop();
  endtask

  task automatic t_glitch();
    send(9'h0F0, 8, 0, 0, 0, 1, 2);
    chk("R12", "glitch on a 0 bit", rx_data, 8'hF0); pop();
    send(9'h0F0, 8, 0, 0, 0, 1, 5);
    chk("R12", "glitch on a 1 bit", rx_data, 8'hF0); pop();
  endtask

  task automatic t_overrun();
    send(9'h011, 8, 0, 0, 0, 1, -1);
    send(9'h022, 8, 0, 0, 0, 1, -1);
    chk("R9", "no ovr at two", rx_ovr, 0);
    send(9'h033, 8, 0, 0, 0, 1, -1);
    chk("R9", "ovr set", rx_ovr, 1);
    chk("R8", "head is first", rx_data, 8'h11);
    pop();
    chk("R9", "ovr cleared by pop", rx_ovr, 0);
    chk("R9", "second kept", rx_data, 8'h22);
    pop();
    chk("R9", "third dropped", rx_valid, 0);
  endtask

  task automatic t_pair();
    rx_size = 3'b111;
    send(9'h100, 9, 0, 0, 0, 1, -1);
    send(9'h0FF, 9, 0, 0, 0, 1, -1);
    chk("R11", "first ninth", rx_bit8, 1);
    chk("R11", "first low", rx_data, 8'h00);
    pop();
    chk("R11", "second ninth", rx_bit8, 0);
    chk("R11", "second low", rx_data, 8'hFF);
    pop();
    rx_size = 3'b011;
  endtask

  task automatic t_flush();
    send(9'h044, 8, 0, 0, 0, 0, -1);
    send(9'h055, 8, 0, 0, 0, 1, -1);
    send(9'h066, 8, 0, 0, 0, 1, -1);
    chk("R10", "setup full", rx_valid, 1);
    chk("R10", "setup ovr", rx_ovr, 1);
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk);
    chk("R10", "valid after disable", rx_valid, 0);
    chk("R10", "ovr after disable", rx_ovr, 0);
    chk("R2", "pin released", rx_pin_own, 0);
    rx_en = 1'b1;
    hold_bits(8);
    chk("R10", "still empty on re-enable", rx_valid, 0);
    send(9'h077, 8, 0, 0, 0, 1, -1);
    chk("R10", "fresh data", rx_data, 8'h77);
    chk("R10", "fresh ferr", rx_ferr, 0); pop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pin_own();
    t_basic();
    t_sizes();
    t_parity();
    t_frame();
    t_false_start();
    t_glitch();
    t_overrun();
    t_pair();
    t_flush();
    report();
  end
endmodule